// File: doc/BRIEF.md
# Sequence-Unlocked Watchdog Reset Timer

This block is a watchdog for a small microcontroller. It stays off after any reset. Software arms it by writing a two-byte key, 0x1E and then 0xE1, to a single write-only register. Once armed, a 13-bit counter advances by one on every machine cycle. Software can only hold off expiry by writing the same two-byte key again, which restarts the count. No write can turn the watchdog off. If the counter runs out, the block drives an active-high reset pulse of fixed length on the oscillator clock. When that pulse ends, the watchdog returns to the disarmed state.

Several low-power states freeze the count. In power-down the oscillator is stopped, so the count holds. In idle, the count keeps running unless a freeze control bit is set. After a power-down that ends through a level-sensitive wake interrupt, the count stays held for as long as the interrupt line is low. It resumes as soon as the line goes high. Register address decoding, the processor core and the oscillator lie outside this block. The block sees a write strobe with its data byte, and a one-cycle machine-cycle enable.

Top module: `wdog_seq_timer`

## Requirements
- R1: After reset the watchdog is disarmed and `wdt_rst_o` is 0. While disarmed, machine cycles never produce a reset pulse.
- R2: The watchdog arms only when a write of 0xE1 follows a write of 0x1E with no other write in between. Cycles without a write between the two keep the first half pending. A write of any other value cancels it. A fresh 0x1E restarts the sequence.
- R3: While armed and not frozen, each cycle with `mc_en` high advances the count. The counter never holds 8191. On the clock edge that samples the 8191st advancing machine cycle since arming or the last service, `wdt_rst_o` goes high.
- R4: Completing the key sequence while armed clears the count to 0, so the pulse moves to 8191 advancing machine cycles after that write.
- R5: No write disarms the watchdog or changes its count, other than a complete key sequence. Only a reset or the end of an expiry pulse disarms it.
- R6: The expiry pulse stays high for exactly 98 clock cycles, regardless of `mc_en`. It is not retriggered while high. Writes during the pulse are ignored. When it ends, the watchdog is disarmed with its count at 0.
- R7: While `pd_active` is high, the count holds its value.
- R8: While `idle_active` is high, the count keeps advancing if `idle_freeze` is 0. It holds if `idle_freeze` is 1, and resumes when idle ends.
- R9: After `pd_active` falls, the count holds while `wake_int_n` is low. It advances again from the first cycle in which `wake_int_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the watchdog key register |
| wr_data | input | 8 | Byte written with the strobe |
| mc_en | input | 1 | One-cycle enable marking a machine cycle |
| pd_active | input | 1 | High while the device is in power-down |
| idle_active | input | 1 | High while the device is in idle |
| idle_freeze | input | 1 | When 1, idle holds the count |
| wake_int_n | input | 1 | Level of the active-low wake interrupt |
| wdt_rst_o | output | 1 | Active-high expiry reset pulse |

## Verification
The bench goes after the following cases:
- A key sequence that is broken by a foreign write, or led by a lone 0xE1. A detector that only matched the last two bytes, or never cleared its pending half, would arm falsely and expire when it should stay silent.
- A service in the middle of a count, mixed with writes that are not keys. A design that let stray writes clear or stop the counter would move the pulse or drop it.
- Sparse machine-cycle enables, idle with and without the freeze bit, and a power-down followed by a wake interrupt held low for a while. Each gating error would move the expected pulse-start cycle.
- The pulse width, and silence for a full period after each expiry. These catch a pulse counter that is off by one or that retriggers, and a watchdog that stays armed after expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'h1E;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'hE1;

  // Power and idle status seen by the count gate
  typedef struct packed {
    logic pd;
    logic idle;
    logic idle_frz;
    logic wake_n;
  } wdog_pwr_t;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_data,
  output logic             kick
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    kick   = 1'b0;
    if (clr) begin
      pend_d = 1'b0;
    end else if (wr_en) begin
      kick   = pend_q && (wr_data == KEY_SECOND);
      pend_d = (wr_data == KEY_FIRST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/wdog_gate.sv
module wdog_gate
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mc_en,
  input  wdog_pwr_t pwr,
  output logic      tick
);

  logic hold_q;
  logic hold_d;
  logic frz_idle;
  logic frz_wake;

  always_comb begin
    frz_idle = pwr.idle && pwr.idle_frz;
    frz_wake = hold_q && !pwr.wake_n;
    tick     = mc_en && !pwr.pd && !frz_idle && !frz_wake;
    if (pwr.pd) begin
      hold_d = 1'b1;
    end else if (pwr.wake_n) begin
      hold_d = 1'b0;
    end else begin
      hold_d = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_CYC = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active,
  output logic done
);

  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYC - 1);

  logic          act_q;
  logic          act_d;
  logic [PW-1:0] left_q;
  logic [PW-1:0] left_d;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    done   = act_q && (left_q == '0);
    if (act_q) begin
      if (done) begin
        act_d = 1'b0;
      end else begin
        left_d = left_q - 1'b1;
      end
    end else if (fire) begin
      act_d  = 1'b1;
      left_d = LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/wdog_seq_timer.sv
module wdog_seq_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter int PULSE_CYC = 98
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             mc_en,
  input  logic             pd_active,
  input  logic             idle_active,
  input  logic             idle_freeze,
  input  logic             wake_int_n,
  output logic             wdt_rst_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic             rst_n_s;
  logic             kick;
  logic             tick;
  logic             adv;
  logic             fire;
  logic             pulse_q;
  logic             pulse_done;
  logic             armed_q;
  logic             armed_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  wdog_pwr_t        pwr;

  wdog_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  wdog_unlock i_unlock (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (pulse_q),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .kick    (kick)
  );

  always_comb begin
    pwr.pd       = pd_active;
    pwr.idle     = idle_active;
    pwr.idle_frz = idle_freeze;
    pwr.wake_n   = wake_int_n;
  end

  wdog_gate i_gate (
    .clk   (clk),
    .rst_n (rst_n_s),
    .mc_en (mc_en),
    .pwr   (pwr),
    .tick  (tick)
  );

  wdog_pulse #(.PULSE_CYC(PULSE_CYC)) i_pulse (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .fire   (fire),
    .active (pulse_q),
    .done   (pulse_done)
  );

  // Next-state for the arm flag and the machine-cycle counter
  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    adv     = armed_q && tick && !pulse_q;
    fire    = 1'b0;
    if (pulse_done) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (kick) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (adv) begin
      if (cnt_q == CNT_LAST) begin
        fire = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wdt_rst_o = pulse_q;

endmodule

// File: rtl/wdog_seq_timer_chk.sv
module wdog_seq_timer_chk #(
  parameter int CNT_W     = 13,
  parameter int PULSE_CYC = 98
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             pd_active,
  input logic             wdt_rst_o,
  input logic             armed_q,
  input logic             kick,
  input logic [CNT_W-1:0] cnt_q
);

  localparam int HW = $clog2(PULSE_CYC + 2) + 1;

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hi_cnt <= '0;
    end else if (wdt_rst_o) begin
      hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
    end
  end

  // R1: disarmed means quiet output and zero count
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    !armed_q |-> (!wdt_rst_o && cnt_q == '0));

  // R3: counter never sits at its all-ones value
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n_s)
    cnt_q != {CNT_W{1'b1}});

  // R4: completed key sequence leaves the watchdog armed with a cleared count
  a_r4_kick_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    kick |=> (armed_q && cnt_q == '0));

  // R5: disarming only follows an expiry pulse
  a_r5_no_soft_disarm: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(armed_q) |-> $past(wdt_rst_o));

  // R6: pulse width and disarm at its end
  a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(wdt_rst_o) |-> (hi_cnt == HW'(PULSE_CYC) && !armed_q));

  // R7: power-down holds the count
  a_r7_pd_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pd_active && !kick && !wdt_rst_o) |=> $stable(cnt_q));

endmodule

bind wdog_seq_timer wdog_seq_timer_chk #(
  .CNT_W     (CNT_W),
  .PULSE_CYC (PULSE_CYC)
) i_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .pd_active (pd_active),
  .wdt_rst_o (wdt_rst_o),
  .armed_q   (armed_q),
  .kick      (kick),
  .cnt_q     (cnt_q)
);

// File: tb/test_wdog_seq_timer.sv
module test_wdog_seq_timer;

  localparam int PERIOD = 8191;
  localparam int PULSE  = 98;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       mc_en;
  logic       pd_active;
  logic       idle_active;
  logic       idle_freeze;
  logic       wake_int_n;
  logic       wdt_rst_o;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int n_rise = 0;
  bit done_flag = 0;
  int exp_q[$];

  // reference state built from the requirements
  bit m_armed = 0;
  bit m_pend  = 0;
  bit m_hold  = 0;
  int m_cnt   = 0;
  int m_rise  = -100000;

  wdog_seq_timer i_wdog_seq_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .mc_en       (mc_en),
    .pd_active   (pd_active),
    .idle_active (idle_active),
    .idle_freeze (idle_freeze),
    .wake_int_n  (wake_int_n),
    .wdt_rst_o   (wdt_rst_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: one machine step, with the reference model advanced for the sampling edge
  task automatic step(input bit w, input logic [7:0] d, input bit mc,
                      input bit pd, input bit idl, input bit frz, input bit intn);
    int  e;
    bit  inp;
    bit  adv;
    bit  kk;
    @(negedge clk);
    wr_en = w; wr_data = d; mc_en = mc; pd_active = pd;
    idle_active = idl; idle_freeze = frz; wake_int_n = intn;
    e   = cyc + 1;
    inp = (e > m_rise) && (e <= m_rise + PULSE);
    adv = m_armed && !inp && mc && !pd && !(idl && frz) && !(m_hold && !intn);
    if (inp) begin
      m_pend = 0;
      if (e == m_rise + PULSE) begin
        m_armed = 0;
        m_cnt   = 0;
      end
    end else begin
      kk = w && m_pend && (d == 8'hE1);
      if (w) m_pend = (d == 8'h1E);
      if (kk) begin
        m_armed = 1;
        m_cnt   = 0;
      end else if (adv) begin
        if (m_cnt == PERIOD - 1) begin
          m_rise = e;
          exp_q.push_back(e);
        end else begin
          m_cnt++;
        end
      end
    end
    m_hold = pd ? 1'b1 : (intn ? 1'b0 : m_hold);
  endtask

  task automatic run(input int n, input bit pd, input bit idl, input bit frz, input bit intn);
    for (int i = 0; i < n; i++) step(0, 8'h00, 1, pd, idl, frz, intn);
  endtask

  task automatic wr(input logic [7:0] d);
    step(1, d, 1, 0, 0, 0, 1);
  endtask

  task automatic key();
    wr(8'h1E);
    wr(8'hE1);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // monitor: pops the expected pulse start and checks the width
  bit mon_prev = 0;
  int mon_len  = 0;
  always @(negedge clk) begin
    if (wdt_rst_o && !mon_prev) begin
      n_rise++;
      mon_len = 1;
      if (exp_q.size() == 0) begin
        chk(0, "R1/R3 unexpected pulse", cyc, -1);
      end else begin
        int ex;
        ex = exp_q.pop_front();
        chk(cyc == ex, "R3 pulse start", cyc, ex);
      end
    end else if (wdt_rst_o) begin
      mon_len++;
    end else if (mon_prev) begin
      chk(mon_len == PULSE, "R6 pulse width", mon_len, PULSE);
    end
    mon_prev = wdt_rst_o;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 190000);
    finish_run();
  end

  initial begin
    int r0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; mc_en = 1'b0;
    pd_active = 1'b0; idle_active = 1'b0; idle_freeze = 1'b0; wake_int_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(wdt_rst_o == 1'b0, "R1 output low in reset", wdt_rst_o, 0);
    rst_n = 1'b1;
    run(10, 0, 0, 0, 1);
    chk(wdt_rst_o == 1'b0, "R1 output low after reset", wdt_rst_o, 0);

    // R1: never armed, no pulse
    r0 = n_rise;
    run(PERIOD + 200, 0, 0, 0, 1);
    chk(n_rise == r0, "R1 no pulse while disarmed", n_rise - r0, 0);

    // R2: lone second key and an interrupted sequence do not arm
    wr(8'hE1);
    wr(8'h1E); wr(8'h55); wr(8'hE1);
    r0 = n_rise;
    run(PERIOD + 200, 0, 0, 0, 1);
    chk(n_rise == r0, "R2 broken sequence stays disarmed", n_rise - r0, 0);

    // R2/R3: pending half survives idle bus cycles; then expire
    wr(8'h1E);
    run(3, 0, 0, 0, 1);
    wr(8'hE1);
    run(PERIOD + 150, 0, 0, 0, 1);
    drained("R3 expiry after arming");

    // R6: disarmed after the pulse, stays quiet
    r0 = n_rise;
    run(PERIOD + 200, 0, 0, 0, 1);
    chk(n_rise == r0, "R6 disarmed after pulse", n_rise - r0, 0);

    // R4/R5: stray writes do not touch the count, a full key restarts it
    key();
    run(5000, 0, 0, 0, 1);
    wr(8'h00); wr(8'hE1); wr(8'h1E); wr(8'h33); wr(8'hE1); wr(8'hFF);
    run(2000, 0, 0, 0, 1);
    key();
    r0 = n_rise;
    run(PERIOD - 200, 0, 0, 0, 1);
    chk(n_rise == r0, "R4 service postpones expiry", n_rise - r0, 0);
    run(400, 0, 0, 0, 1);
    drained("R4 expiry after service");

    // R3/R2: double first key, then sparse machine cycles
    wr(8'h1E); wr(8'h1E); wr(8'hE1);
    for (int i = 0; i < 2 * PERIOD + 200; i++) step(0, 8'h00, (i % 2) == 0, 0, 0, 0, 1);
    drained("R3 sparse machine cycles");

    // R8: idle with freeze bit clear keeps counting
    key();
    run(PERIOD + 150, 0, 1, 0, 1);
    drained("R8 idle counting");

    // R8: idle with freeze bit set holds
    key();
    run(3000, 0, 0, 0, 1);
    run(2500, 0, 1, 1, 1);
    r0 = n_rise;
    run(PERIOD - 3200, 0, 0, 0, 1);
    chk(n_rise == r0, "R8 idle freeze holds", n_rise - r0, 0);
    run(400, 0, 0, 0, 1);
    drained("R8 expiry after idle freeze");

    // R7/R9: power-down, then wake interrupt held low
    key();
    run(3000, 0, 0, 0, 1);
    run(600, 1, 0, 0, 0);
    run(400, 0, 0, 0, 0);
    r0 = n_rise;
    run(PERIOD - 3100, 0, 0, 0, 1);
    chk(n_rise == r0, "R7 R9 frozen through power-down and wake", n_rise - r0, 0);
    run(300, 0, 0, 0, 1);
    drained("R9 expiry after wake");

    run(20, 0, 0, 0, 1);
    finish_run();
  end

endmodule